// File: doc/BRIEF.md
# Receive Control Word Checker

This block watches the 16-bit word stream on the receive side of a source-synchronous packet interface of the SPI-4.2 kind. Each word carries a flag that marks it as control or data. The checker decodes every valid control word. Payload control words open and address a packet. Idle control words close one. Extension words and the reserved patterns are also picked out.

The block keeps a running 4-bit diagonal parity over the data words and checks it against the parity field of the next control word. Data words go to a buffer write port tagged with their channel. Words that arrive after a reserved control word are held back from that port. A parity failure raises a one-cycle error pulse. When marking is enabled, the same failure also flags every channel that has a packet in progress.

All outputs are registered. Each output reflects the input word accepted on the previous clock edge.

Top module: `ctlword_checker`

## Requirements
- R1: A valid control word whose bits [15:12] equal 4'b0101, 4'b0011 or 4'b0111 is reserved, and `rsv_pulse` is high for exactly the one cycle after that word is accepted.
- R2: After a reserved control word, data words do not assert `wr_en`, until the next valid control word that is not reserved.
- R3: A valid control word with bits [15:12] equal to 4'b0001 is an extension word. It pulses `ext_pulse` for one cycle, does not pulse `rsv_pulse`, and ends the discard of R2.
- R4: A control word with bit 15 set is a payload word. It selects channel bits [11:4], which must be below NCH. Each following data word is presented one cycle later on `wr_en`/`wr_data`/`wr_chan` for that channel. An address of NCH or above, or any non-payload, non-reserved control word, stops writes.
- R5: The parity accumulator starts at zero after reset and after every control word. Each accepted word updates it as acc = rotate-left-by-one(acc) XOR word. For a control word, bits [3:0] are taken as 4'b1111 in this update. Expected parity bit i is acc[i]^acc[i+4]^acc[i+8]^acc[i+12].
- R6: If a control word's bits [3:0] differ from the expected parity, `dip_err` is high for one cycle. If they match, it stays low.
- R7: A channel's packet is open from a payload word with bit 12 (start) set. It stays open until a payload or idle control word carries a non-zero end code in bits [14:13] while that channel is the active one. A start on the same channel in that same word wins.
- R8: On a parity failure with `mark_en` high, `err_mark` pulses with a bit set for every channel open before the word, plus the channel the failing word itself starts. With `mark_en` low, `err_mark` stays zero.
- R9: During and right after reset, all outputs are zero and no channel is open.
- R10: A cycle with `in_valid` low changes no state and produces no pulse or write, whatever `in_ctl` and `in_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on `in_data` is valid this cycle |
| in_ctl | input | 1 | Word is a control word |
| in_data | input | 16 | Received word |
| mark_en | input | 1 | Enables error marking of open packets |
| wr_en | output | 1 | Buffer write strobe |
| wr_data | output | 16 | Payload word to write |
| wr_chan | output | CHW (2 by default) | Channel of the written word |
| rsv_pulse | output | 1 | Reserved control word seen |
| ext_pulse | output | 1 | Extension control word seen |
| dip_err | output | 1 | Parity mismatch on the last control word |
| err_mark | output | NCH (4 by default) | Per-channel error mark |

## Verification
Packets are swept over all four channels, data runs of zero to three words, every end code, and both settings of the marking enable. The start word is good in some runs and corrupted in others. A corrupted start word shows that the opening channel itself is marked and that parity is folded over the right words. Two packets left open across a channel switch, then closed by a failing idle word, show that marks cover every open channel and not just the active one. Each reserved pattern and the extension pattern is followed by data and then by a fresh payload word, which tells discard apart from a plain end of packet. Idle gaps with garbage on the data lines confirm that invalid cycles leave the parity and the packet state alone.

// File: rtl/cwchk_pkg.sv
package cwchk_pkg;

    localparam int WORD_W = 16;
    localparam int PAR_W  = 4;
    localparam int ADR_W  = 8;

    typedef enum logic [1:0] {
        CW_IDLE     = 2'd0,
        CW_PAYLOAD  = 2'd1,
        CW_RESERVED = 2'd2,
        CW_EXTEND   = 2'd3
    } cw_kind_e;

    typedef struct packed {
        cw_kind_e         kind;
        logic             sop;
        logic [1:0]       eop_code;
        logic [ADR_W-1:0] adr;
    } cw_info_t;

    function automatic cw_kind_e kind_of(logic [3:0] nib);
        cw_kind_e k;
        if (nib[3])
            k = CW_PAYLOAD;
        else if (nib == 4'b0101 || nib == 4'b0011 || nib == 4'b0111)
            k = CW_RESERVED;
        else if (nib == 4'b0001)
            k = CW_EXTEND;
        else
            k = CW_IDLE;
        return k;
    endfunction

    function automatic logic [WORD_W-1:0] par_step(logic [WORD_W-1:0] acc,
                                                   logic [WORD_W-1:0] w);
        return {acc[WORD_W-2:0], acc[WORD_W-1]} ^ w;
    endfunction

    function automatic logic [PAR_W-1:0] par_fold(logic [WORD_W-1:0] acc);
        logic [PAR_W-1:0] f;
        f = '0;
        for (int i = 0; i < WORD_W; i++)
            f[i % PAR_W] = f[i % PAR_W] ^ acc[i];
        return f;
    endfunction

endpackage

// File: rtl/cwchk_decode.sv
module cwchk_decode
    import cwchk_pkg::*;
(
    input  logic [WORD_W-1:PAR_W] hdr,
    output cw_info_t              info
);
    always_comb begin
        info.kind     = kind_of(hdr[15:12]);
        info.eop_code = hdr[14:13];
        info.sop      = hdr[12];
        info.adr      = hdr[11:4];
    end
endmodule

// File: rtl/cwchk_parity.sv
module cwchk_parity
    import cwchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ctl,
    input  logic [WORD_W-1:0] in_data,
    output logic              par_bad,
    output logic              dip_err
);
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_in;
    logic [WORD_W-1:0] folded_word;

    always_comb begin
        folded_word = in_ctl ? {in_data[WORD_W-1:PAR_W], {PAR_W{1'b1}}} : in_data;
        acc_in      = par_step(acc_q, folded_word);
        par_bad     = in_valid && in_ctl && (par_fold(acc_in) != in_data[PAR_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            dip_err <= 1'b0;
        end else begin
            dip_err <= par_bad;
            if (in_valid)
                acc_q <= in_ctl ? '0 : acc_in;
        end
    end

    assert_dip_from_ctl_R6: assert property (@(posedge clk) disable iff (rst)
        dip_err |-> $past(in_valid && in_ctl));

    assert_acc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc_q));

    assert_acc_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctl) |=> (acc_q == '0));
endmodule

// File: rtl/cwchk_tracker.sv
module cwchk_tracker
    import cwchk_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ctl,
    input  logic [WORD_W-1:0] in_data,
    input  cw_info_t          info,
    input  logic              par_bad,
    input  logic              mark_en,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic [CHW-1:0]    wr_chan,
    output logic              rsv_pulse,
    output logic              ext_pulse,
    output logic [NCH-1:0]    err_mark
);
    logic [NCH-1:0] open_q;
    logic [NCH-1:0] sop_hit;
    logic [NCH-1:0] eop_hit;
    logic           in_pkt_q;
    logic           discard_q;
    logic [CHW-1:0] cur_q;
    logic           is_ctl, is_dat, is_pay, chan_ok, eop_seen;
    logic [CHW-1:0] new_ch;

    always_comb begin
        is_ctl   = in_valid && in_ctl;
        is_dat   = in_valid && !in_ctl;
        is_pay   = is_ctl && (info.kind == CW_PAYLOAD);
        chan_ok  = int'(info.adr) < NCH;
        new_ch   = info.adr[CHW-1:0];
        eop_seen = is_ctl && in_pkt_q && (info.eop_code != 2'b00)
                   && (info.kind == CW_IDLE || info.kind == CW_PAYLOAD);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign sop_hit[g] = is_pay && info.sop && chan_ok && (new_ch == CHW'(g));
        assign eop_hit[g] = eop_seen && (cur_q == CHW'(g));

        always_ff @(posedge clk) begin
            if (rst)
                open_q[g] <= 1'b0;
            else if (sop_hit[g])
                open_q[g] <= 1'b1;
            else if (eop_hit[g])
                open_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en     <= 1'b0;
            wr_data   <= '0;
            wr_chan   <= '0;
            rsv_pulse <= 1'b0;
            ext_pulse <= 1'b0;
            err_mark  <= '0;
            in_pkt_q  <= 1'b0;
            discard_q <= 1'b0;
            cur_q     <= '0;
        end else begin
            wr_en     <= is_dat && in_pkt_q && !discard_q;
            wr_data   <= in_data;
            wr_chan   <= cur_q;
            rsv_pulse <= is_ctl && (info.kind == CW_RESERVED);
            ext_pulse <= is_ctl && (info.kind == CW_EXTEND);
            err_mark  <= (par_bad && mark_en) ? (open_q | sop_hit) : '0;
            if (is_ctl) begin
                discard_q <= (info.kind == CW_RESERVED);
                if (info.kind == CW_PAYLOAD) begin
                    in_pkt_q <= chan_ok;
                    cur_q    <= new_ch;
                end else if (info.kind != CW_RESERVED) begin
                    in_pkt_q <= 1'b0;
                end
            end
        end
    end

    assert_rsv_from_ctl_R1: assert property (@(posedge clk) disable iff (rst)
        rsv_pulse |-> $past(in_valid && in_ctl));

    assert_discard_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (discard_q && in_valid && !in_ctl) |=> !wr_en);

    assert_ext_ends_discard_R3: assert property (@(posedge clk) disable iff (rst)
        ext_pulse |-> !discard_q);

    assert_wr_from_data_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(in_valid && !in_ctl));

    assert_mark_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (err_mark != '0) |-> $past(mark_en));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wr_en && !rsv_pulse && !ext_pulse));
endmodule

// File: rtl/ctlword_checker.sv
module ctlword_checker
    import cwchk_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ctl,
    input  logic [15:0]       in_data,
    input  logic              mark_en,
    output logic              wr_en,
    output logic [15:0]       wr_data,
    output logic [CHW-1:0]    wr_chan,
    output logic              rsv_pulse,
    output logic              ext_pulse,
    output logic              dip_err,
    output logic [NCH-1:0]    err_mark
);
    cw_info_t info;
    logic     par_bad;

    cwchk_decode u_decode (
        .hdr  (in_data[WORD_W-1:PAR_W]),
        .info (info)
    );

    cwchk_parity u_parity (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ctl   (in_ctl),
        .in_data  (in_data),
        .par_bad  (par_bad),
        .dip_err  (dip_err)
    );

    cwchk_tracker #(.NCH(NCH), .CHW(CHW)) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ctl    (in_ctl),
        .in_data   (in_data),
        .info      (info),
        .par_bad   (par_bad),
        .mark_en   (mark_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_chan   (wr_chan),
        .rsv_pulse (rsv_pulse),
        .ext_pulse (ext_pulse),
        .err_mark  (err_mark)
    );

    assert_mark_needs_dip_R8: assert property (@(posedge clk) disable iff (rst)
        (err_mark != '0) |-> dip_err);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (!wr_en && !rsv_pulse && !ext_pulse && !dip_err && err_mark == '0));
endmodule

// File: tb/ctlword_checker_test.sv
`timescale 1ns/1ps
module ctlword_checker_test;
    localparam int NCH = 4;
    localparam int CHW = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ctl = 1'b0;
    logic [15:0]    in_data = '0;
    logic           mark_en = 1'b0;
    logic           wr_en;
    logic [15:0]    wr_data;
    logic [CHW-1:0] wr_chan;
    logic           rsv_pulse, ext_pulse, dip_err;
    logic [NCH-1:0] err_mark;

    int errors = 0;
    int checks = 0;

    // bench-side model state
    logic [15:0]    m_acc = '0;
    logic [NCH-1:0] m_open = '0;
    bit             m_inpkt = 0;
    bit             m_disc = 0;
    int             m_cur = 0;

    always #2 clk = ~clk;

    ctlword_checker #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctl(in_ctl),
        .in_data(in_data), .mark_en(mark_en), .wr_en(wr_en), .wr_data(wr_data),
        .wr_chan(wr_chan), .rsv_pulse(rsv_pulse), .ext_pulse(ext_pulse),
        .dip_err(dip_err), .err_mark(err_mark)
    );

    function automatic logic [15:0] b_rot(logic [15:0] a);
        return (a << 1) | (a >> 15);
    endfunction

    function automatic logic [3:0] b_fold(logic [15:0] a);
        return a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One input cycle: compute expectations, clock, compare.
    task automatic put(input bit v, input bit c, input logic [15:0] d);
        bit e_wr = 0, e_rsv = 0, e_ext = 0, e_dip = 0;
        logic [NCH-1:0] e_mark = '0;
        logic [NCH-1:0] sopm = '0;
        int e_ch = m_cur;
        logic [15:0] a;
        if (v && !c) begin
            m_acc = b_rot(m_acc) ^ d;
            e_wr  = m_inpkt && !m_disc;
        end else if (v && c) begin
            int nib = d[15:12];
            bit pay = d[15];
            bit rsv = !pay && (nib == 5 || nib == 3 || nib == 7);
            bit ext = !pay && nib == 1;
            int adr = d[11:4];
            a = b_rot(m_acc) ^ {d[15:4], 4'hF};
            e_dip = b_fold(a) != d[3:0];
            m_acc = '0;
            e_rsv = rsv;
            e_ext = ext;
            if (pay && d[12] && adr < NCH) sopm[adr] = 1'b1;
            if (e_dip && mark_en) e_mark = m_open | sopm;
            if (!rsv && !ext && d[14:13] != 0 && m_inpkt) m_open[m_cur] = 1'b0;
            m_open = m_open | sopm;
            m_disc = rsv;
            if (pay) begin
                m_inpkt = adr < NCH;
                m_cur   = adr % NCH;
            end else if (!rsv) begin
                m_inpkt = 0;
            end
        end
        in_valid = v; in_ctl = c; in_data = d;
        @(posedge clk); #1;
        chk(wr_en == e_wr, e_wr ? "R4 write strobe" : "R2/R4/R10 write blocked", wr_en, e_wr);
        if (e_wr) begin
            chk(wr_data == d, "R4 write data", wr_data, d);
            chk(wr_chan == CHW'(e_ch), "R4 write channel", wr_chan, e_ch);
        end
        chk(rsv_pulse == e_rsv, "R1 reserved pulse", rsv_pulse, e_rsv);
        chk(ext_pulse == e_ext, "R3 extension pulse", ext_pulse, e_ext);
        chk(dip_err == e_dip, "R5/R6 parity error", dip_err, e_dip);
        chk(err_mark == e_mark, "R7/R8 error mark", err_mark, e_mark);
        in_valid = 0; in_ctl = 0; in_data = 16'hDEAD;
    endtask

    // control word with parity computed from the model accumulator
    task automatic ctl(input logic [11:0] hi, input bit corrupt);
        logic [3:0] p = b_fold(b_rot(m_acc) ^ {hi, 4'hF});
        if (corrupt) p = p ^ 4'h5;
        put(1, 1, {hi, p});
    endtask

    task automatic dat(input logic [15:0] d);
        put(1, 0, d);
    endtask

    task automatic idle_gap();
        put(0, 1, 16'h5A5A);
        put(0, 0, 16'h1234);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        // R9: outputs zero while in reset
        chk({wr_en, rsv_pulse, ext_pulse, dip_err, err_mark} == 0, "R9 reset outputs",
            {wr_en, rsv_pulse, ext_pulse, dip_err, err_mark}, 0);
        rst = 0;
        @(posedge clk); #1;
        chk({wr_en, rsv_pulse, ext_pulse, dip_err, err_mark} == 0, "R9 after reset",
            {wr_en, rsv_pulse, ext_pulse, dip_err, err_mark}, 0);

        // Sweep: channel, length, corrupted start word, marking enable
        for (int me = 0; me < 2; me++) begin
            mark_en = me[0];
            for (int ch = 0; ch < NCH; ch++)
                for (int len = 0; len < 4; len++)
                    for (int bad = 0; bad < 2; bad++) begin
                        ctl({1'b1, 2'b00, 1'b1, 8'(ch)}, bad[0]);
                        for (int k = 0; k < len; k++) begin
                            dat(16'(k * 16'h1357 ^ ch * 16'h0F0F ^ len));
                            if (k == 1) idle_gap();
                        end
                        ctl({1'b0, 2'(1 + len % 3), 1'b0, 8'h00}, (len == 2) && bad[0]);
                    end
        end

        // R7/R8: two packets left open across a channel switch
        mark_en = 1;
        ctl({1'b1, 2'b00, 1'b1, 8'd0}, 0);
        dat(16'hA001);
        ctl({1'b1, 2'b00, 1'b1, 8'd3}, 0);
        dat(16'hA002);
        ctl({1'b0, 2'b00, 1'b0, 8'h00}, 1);
        ctl({1'b1, 2'b00, 1'b0, 8'd0}, 0);
        dat(16'hA003);
        ctl({1'b0, 2'b10, 1'b0, 8'h00}, 1);
        ctl({1'b1, 2'b00, 1'b0, 8'd3}, 0);
        ctl({1'b1, 2'b11, 1'b1, 8'd3}, 1);
        ctl({1'b0, 2'b01, 1'b0, 8'h00}, 0);

        // R4: out-of-range address drops data
        ctl({1'b1, 2'b00, 1'b1, 8'h40}, 0);
        dat(16'hB0B0);
        ctl({1'b0, 2'b00, 1'b0, 8'h00}, 1);

        // R1/R2/R3: reserved and extension words followed by data
        for (int r = 0; r < 4; r++) begin
            logic [3:0] nib = (r == 0) ? 4'b0101 : (r == 1) ? 4'b0011 :
                              (r == 2) ? 4'b0111 : 4'b0001;
            ctl({1'b1, 2'b00, 1'b1, 8'(r)}, 0);
            dat(16'hC000 + 16'(r));
            ctl({nib, 8'(r * 16 + 3)}, r == 1);
            dat(16'hC100 + 16'(r));
            idle_gap();
            dat(16'hC200 + 16'(r));
            ctl({nib, 8'h00}, 0);
            dat(16'hC300 + 16'(r));
            ctl({1'b1, 2'b01, 1'b0, 8'(r)}, 0);
            dat(16'hC400 + 16'(r));
            ctl({1'b0, 2'b10, 1'b0, 8'h00}, 0);
        end

        // R10: long invalid stretch then a good word
        for (int i = 0; i < 8; i++) put(0, i[0], 16'(i * 16'h1111));
        ctl({1'b0, 2'b00, 1'b0, 8'h00}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule